// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a chip. A serial test clock, a mode-select line and a data-in line step a sixteen-state controller. Through that controller an external tester loads a 4-bit instruction and then reads or writes the data register that the instruction picks. Three data registers are held here: a 32-bit device identity word, a 1-bit bypass stage and a boundary-scan chain of parameterised length. The chain captures the pin-side inputs in parallel and drives an update stage toward the pads. Two opcodes belong to a separate debug-port controller. For those, the block raises a select flag and passes that controller's serial output through to the data-out line. Three further opcodes are set aside for factory debug. For those, the block raises a flag and uses the bypass path.

Loaded instructions also drive chip-level controls. These are a functional-reset request, a flag that hands the pads to the boundary-scan update stage, and a pad three-state request. All controls take a new value only when an instruction is committed, or when the controller falls back to its reset state. The test reset input is synchronous to the test clock and active high.

Top module: `tap_ctrl`

## Requirements
- R1: The controller enters Test-Logic-Reset after `trst` is sampled high, or after five consecutive rising `tck` edges with `tms` high. Leaving that state, the active instruction is 0000 (identity register) with all control flags low. `trst` also clears `pin_out` to zero.
- R2: In Capture-IR the instruction shifter loads 0001. Shift-IR moves it LSB first (bit 0 appears first on `tdo`). The new instruction, and every flag decoded from it, changes only at the Update-IR edge.
- R3: Opcode 0000 selects a 32-bit register that reads back the `IDCODE` parameter LSB first, with bit 0 forced to 1.
- R4: Any opcode not listed in R3 or R5–R10 (0001 and 1011–1111) selects the 1-bit bypass register. It captures 0, so `tdo` shows 0 first and then `tdi` delayed by one shift. All flags stay low.
- R5: Opcode 0011 captures `pin_in` into the chain in Capture-DR, and the chain reads back LSB first (`pin_in[0]` first). Update-DR leaves `pin_out` unchanged, and all flags stay low.
- R6: Opcode 0010 writes the shifted chain into `pin_out` at Update-DR, with all flags low. `pin_out` changes at no other state.
- R7: Opcode 0100 raises `pin_ext` and `func_rst`, keeps the previously loaded `pin_out`, and also writes `pin_out` at Update-DR.
- R8: Opcode 1001 raises `pin_hiz` and `func_rst` and selects the bypass register.
- R9: Opcodes 1000 and 1010 raise `dbg_sel`. During Shift-DR, `tdo` carries `dbg_tdo`.
- R10: Opcodes 0101, 0110 and 0111 raise `fdbg_sel` and select the bypass register.
- R11: When Shift-DR is left after k shifts (k smaller than the chain length), Update-DR still writes the chain. That chain holds the captured word shifted right by k, with the k `tdi` bits entering at the MSB end.
- R12: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is high only in Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst | input | 1 | Synchronous active-high test reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| dbg_tdo | input | 1 | Serial output of the external debug-port controller |
| pin_in | input | BSR_W | Pin-side values captured by the chain |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| pin_out | output | BSR_W | Boundary-scan update stage toward the pads |
| pin_ext | output | 1 | Pads take their values from `pin_out` |
| pin_hiz | output | 1 | Pads three-stated |
| func_rst | output | 1 | Functional reset request |
| dbg_sel | output | 1 | Forwarded debug-port opcode active |
| fdbg_sel | output | 1 | Factory-debug opcode active |

## Verification
A controller state that drifts from the tester's model shows on the first bit of the next scan. The captured IR pattern, the identity word or the bypass zero is misplaced, or `tdo_oe` rises a cycle early or late. A wrong decoded instruction shows on the control flags one edge after Update-IR. A broken update stage shows as a `pin_out` change outside Update-DR, or a missing change there. Partial shifts, TMS-only resets and a reset raised mid-scan are driven on purpose, so that state damage appears within a single scan.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SELDR, S_CAPDR, S_SHDR, S_EX1DR, S_PADR, S_EX2DR,
    S_UPDR, S_SELIR, S_CAPIR, S_SHIR, S_EX1IR, S_PAIR, S_EX2IR, S_UPIR
  } tap_state_e;

  localparam int IR_W = 4;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  localparam logic [IR_W-1:0] OP_ID      = 4'b0000;
  localparam logic [IR_W-1:0] OP_PRELOAD = 4'b0010;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0011;
  localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0100;
  localparam logic [IR_W-1:0] OP_FDBG0   = 4'b0101;
  localparam logic [IR_W-1:0] OP_FDBG1   = 4'b0110;
  localparam logic [IR_W-1:0] OP_FDBG2   = 4'b0111;
  localparam logic [IR_W-1:0] OP_DBG0    = 4'b1000;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 4'b1001;
  localparam logic [IR_W-1:0] OP_DBG1    = 4'b1010;

  typedef enum logic [1:0] {DR_BYP, DR_ID, DR_BSR, DR_EXT} dr_sel_e;

  typedef struct packed {
    dr_sel_e sel;
    logic    upd_en;
    logic    ext;
    logic    hiz;
    logic    frst;
    logic    dbg;
    logic    fdbg;
  } ir_dec_t;

  function automatic ir_dec_t decode(input logic [IR_W-1:0] op);
    ir_dec_t d;
    d = '{sel: DR_BYP, default: 1'b0};
    case (op)
      OP_ID:      d.sel = DR_ID;
      OP_SAMPLE:  d.sel = DR_BSR;
      OP_PRELOAD: begin d.sel = DR_BSR; d.upd_en = 1'b1; end
      OP_EXTEST:  begin d.sel = DR_BSR; d.upd_en = 1'b1; d.ext = 1'b1; d.frst = 1'b1; end
      OP_HIGHZ:   begin d.hiz = 1'b1; d.frst = 1'b1; end
      OP_DBG0, OP_DBG1: begin d.sel = DR_EXT; d.dbg = 1'b1; end
      OP_FDBG0, OP_FDBG1, OP_FDBG2: d.fdbg = 1'b1;
      default: ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      S_TLR:   nxt = tms ? S_TLR   : S_RTI;
      S_RTI:   nxt = tms ? S_SELDR : S_RTI;
      S_SELDR: nxt = tms ? S_SELIR : S_CAPDR;
      S_CAPDR: nxt = tms ? S_EX1DR : S_SHDR;
      S_SHDR:  nxt = tms ? S_EX1DR : S_SHDR;
      S_EX1DR: nxt = tms ? S_UPDR  : S_PADR;
      S_PADR:  nxt = tms ? S_EX2DR : S_PADR;
      S_EX2DR: nxt = tms ? S_UPDR  : S_SHDR;
      S_UPDR:  nxt = tms ? S_SELDR : S_RTI;
      S_SELIR: nxt = tms ? S_TLR   : S_CAPIR;
      S_CAPIR: nxt = tms ? S_EX1IR : S_SHIR;
      S_SHIR:  nxt = tms ? S_EX1IR : S_SHIR;
      S_EX1IR: nxt = tms ? S_UPIR  : S_PAIR;
      S_PAIR:  nxt = tms ? S_EX2IR : S_PAIR;
      S_EX2IR: nxt = tms ? S_UPIR  : S_SHIR;
      S_UPIR:  nxt = tms ? S_SELDR : S_RTI;
      default: nxt = S_TLR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_TLR;
    else     state <= nxt;
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tdi,
  input  tap_state_e state,
  output logic       ir_lsb,
  output ir_dec_t    dec
);

  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge clk) begin
    if (rst || state == S_TLR) begin
      ir_sh <= '0;
      dec   <= decode(OP_ID);
    end else begin
      case (state)
        S_CAPIR: ir_sh <= IR_CAPTURE;
        S_SHIR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        S_UPIR:  dec   <= decode(ir_sh);
        default: ;
      endcase
    end
  end

  assign ir_lsb = ir_sh[0];

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int          BSR_W  = 8,
  parameter logic [31:0] IDCODE = 32'h0000_0001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tdi,
  input  tap_state_e       state,
  input  dr_sel_e          sel,
  input  logic             upd_en,
  input  logic [BSR_W-1:0] pin_in,
  output logic             dr_lsb,
  output logic [BSR_W-1:0] pin_out
);

  localparam int ID_W = 32;
  localparam logic [ID_W-1:0] ID_VAL = {IDCODE[ID_W-1:1], 1'b1};

  logic [ID_W-1:0]  id_sh;
  logic             byp_q;
  logic [BSR_W-1:0] bsr_sh;
  logic [BSR_W-1:0] bsr_nx;

  generate
    if (BSR_W > 1) begin : g_wide
      assign bsr_nx = {tdi, bsr_sh[BSR_W-1:1]};
    end else begin : g_one
      assign bsr_nx = tdi;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      id_sh   <= ID_VAL;
      byp_q   <= 1'b0;
      bsr_sh  <= '0;
      pin_out <= '0;
    end else begin
      case (state)
        S_CAPDR: begin
          id_sh  <= ID_VAL;
          byp_q  <= 1'b0;
          bsr_sh <= pin_in;
        end
        S_SHDR: begin
          case (sel)
            DR_ID:   id_sh  <= {tdi, id_sh[ID_W-1:1]};
            DR_BYP:  byp_q  <= tdi;
            DR_BSR:  bsr_sh <= bsr_nx;
            default: ;
          endcase
        end
        S_UPDR: if (upd_en && sel == DR_BSR) pin_out <= bsr_sh;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      DR_ID:   dr_lsb = id_sh[0];
      DR_BSR:  dr_lsb = bsr_sh[0];
      DR_BYP:  dr_lsb = byp_q;
      default: dr_lsb = 1'b0;
    endcase
  end

endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
#(
  parameter int          BSR_W  = 8,
  parameter logic [31:0] IDCODE = 32'h0000_0001
) (
  input  logic             tck,
  input  logic             trst,
  input  logic             tms,
  input  logic             tdi,
  input  logic             dbg_tdo,
  input  logic [BSR_W-1:0] pin_in,
  output logic             tdo,
  output logic             tdo_oe,
  output logic [BSR_W-1:0] pin_out,
  output logic             pin_ext,
  output logic             pin_hiz,
  output logic             func_rst,
  output logic             dbg_sel,
  output logic             fdbg_sel
);

  tap_state_e state;
  ir_dec_t    dec;
  logic       ir_lsb;
  logic       dr_lsb;
  logic       tdo_nx;

  tap_fsm u_fsm (.clk(tck), .rst(trst), .tms(tms), .state(state));

  tap_ir u_ir (
    .clk(tck), .rst(trst), .tdi(tdi), .state(state),
    .ir_lsb(ir_lsb), .dec(dec)
  );

  tap_dr #(.BSR_W(BSR_W), .IDCODE(IDCODE)) u_dr (
    .clk(tck), .rst(trst), .tdi(tdi), .state(state),
    .sel(dec.sel), .upd_en(dec.upd_en), .pin_in(pin_in),
    .dr_lsb(dr_lsb), .pin_out(pin_out)
  );

  always_comb begin
    if (state == S_SHIR)      tdo_nx = ir_lsb;
    else if (state == S_SHDR) tdo_nx = (dec.sel == DR_EXT) ? dbg_tdo : dr_lsb;
    else                      tdo_nx = 1'b0;
  end

  always_ff @(negedge tck) begin
    if (trst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_nx;
      tdo_oe <= (state == S_SHIR) || (state == S_SHDR);
    end
  end

  assign pin_ext  = dec.ext;
  assign pin_hiz  = dec.hiz;
  assign func_rst = dec.frst;
  assign dbg_sel  = dec.dbg;
  assign fdbg_sel = dec.fdbg;

endmodule

// File: rtl/tap_chk.sv
module tap_chk
  import tap_pkg::*;
#(
  parameter int BSR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tms,
  input tap_state_e       st,
  input logic [BSR_W-1:0] pin_out,
  input logic [4:0]       flags
);

  logic [2:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst || !tms)         hi_cnt <= 3'd0;
    else if (hi_cnt != 3'd5) hi_cnt <= hi_cnt + 3'd1;
  end

  AST_TMS_FIVE_RESET: assert property (@(posedge clk) disable iff (rst) (hi_cnt == 3'd5) |-> (st == S_TLR)); // R1
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst) (st != S_UPIR && st != S_TLR) |=> $stable(flags)); // R2
  AST_PIN_OUT_HOLD: assert property (@(posedge clk) disable iff (rst) (st != S_UPDR) |=> $stable(pin_out)); // R6
  AST_EXT_RESET: assert property (@(posedge clk) disable iff (rst) flags[4] |-> flags[2]); // R7
  AST_HIZ_RESET: assert property (@(posedge clk) disable iff (rst) flags[3] |-> flags[2]); // R8
  AST_SEL_EXCL: assert property (@(posedge clk) disable iff (rst) $onehot0({flags[4], flags[3], flags[1], flags[0]})); // R9

endmodule

bind tap_ctrl tap_chk #(.BSR_W(BSR_W)) u_chk (
  .clk(tck), .rst(trst), .tms(tms), .st(state), .pin_out(pin_out),
  .flags({pin_ext, pin_hiz, func_rst, dbg_sel, fdbg_sel})
);

// File: tb/tb_tap_ctrl.sv
module tb_tap_ctrl;

  localparam int          TCK_P  = 10;
  localparam int          BSR_W  = 12;
  localparam logic [31:0] IDCODE = 32'h0A5C_3E14;
  localparam logic [31:0] ID_EXP = {IDCODE[31:1], 1'b1};

  logic             tck = 1'b0;
  logic             trst, tms, tdi, dbg_tdo;
  logic [BSR_W-1:0] pin_in;
  logic             tdo, tdo_oe, pin_ext, pin_hiz, func_rst, dbg_sel, fdbg_sel;
  logic [BSR_W-1:0] pin_out;

  int nchk = 0;
  int nfail = 0;
  logic [BSR_W-1:0] exp_pout;

  tap_ctrl #(.BSR_W(BSR_W), .IDCODE(IDCODE)) dut (
    .tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .dbg_tdo(dbg_tdo),
    .pin_in(pin_in), .tdo(tdo), .tdo_oe(tdo_oe), .pin_out(pin_out),
    .pin_ext(pin_ext), .pin_hiz(pin_hiz), .func_rst(func_rst),
    .dbg_sel(dbg_sel), .fdbg_sel(fdbg_sel)
  );

  always #(TCK_P/2) tck = ~tck;

  initial begin
    #(TCK_P * 200000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk + 1, nfail);
    $finish;
  end

  // {ext, hiz, frst, dbg, fdbg}
  function automatic logic [4:0] exp_flags(input logic [3:0] op);
    case (op)
      4'b0100: return 5'b10100;
      4'b1001: return 5'b01100;
      4'b1000, 4'b1010: return 5'b00010;
      4'b0101, 4'b0110, 4'b0111: return 5'b00001;
      default: return 5'b00000;
    endcase
  endfunction

  function automatic bit is_bypass(input logic [3:0] op);
    return !(op inside {4'b0000, 4'b0010, 4'b0011, 4'b0100, 4'b1000, 4'b1010});
  endfunction

  function automatic logic [BSR_W-1:0] part_shift(input logic [BSR_W-1:0] c,
                                                  input logic [BSR_W-1:0] d, input int k);
    logic [BSR_W-1:0] s;
    s = c;
    for (int i = 0; i < k; i++) s = {d[i], s[BSR_W-1:1]};
    return s;
  endfunction

  function automatic logic [4:0] flags_now();
    return {pin_ext, pin_hiz, func_rst, dbg_sel, fdbg_sel};
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Starts and ends just after a falling edge.
  task automatic step(input logic m, input logic d, output logic o);
    o = tdo;
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic load_ir(input logic [3:0] op, output logic [3:0] cap);
    logic o;
    step(1'b1, 1'b0, o);
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, op[i], o);
      cap[i] = o;
    end
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din,
                         output logic [63:0] dout, output logic oe_all);
    logic o;
    dout = '0;
    oe_all = 1'b1;
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    for (int i = 0; i < n; i++) begin
      oe_all &= tdo_oe;
      step(i == n - 1, din[i], o);
      dout[i] = o;
    end
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
  endtask

  task automatic bypass_check(input string req);
    logic [63:0] din, dout;
    logic oe;
    din = {32'h0, $urandom};
    scan_dr(8, din, dout, oe);
    check(dout[7:0], {din[6:0], 1'b0}, req);
  endtask

  initial begin
    logic o;
    logic [3:0] cap, op;
    logic [63:0] din, dout;
    logic oe, t_a, t_b;
    logic [BSR_W-1:0] c, d;
    void'($urandom(32'd1149));
    trst = 1'b1; tms = 1'b1; tdi = 1'b0; dbg_tdo = 1'b0; pin_in = '0; exp_pout = '0;
    @(negedge tck); #1;
    step(1'b1, 1'b0, o);
    step(1'b1, 1'b0, o);
    trst = 1'b0;
    step(1'b0, 1'b0, o);
    check(flags_now(), 5'b0, "R1 flags after trst");
    check(pin_out, '0, "R1 pin_out after trst");
    check(tdo_oe, 1'b0, "R12 oe idle");

    load_ir(4'b0000, cap);
    check(cap, 4'b0001, "R2 IR capture pattern");
    scan_dr(32, 64'h0, dout, oe);
    check(dout[31:0], ID_EXP, "R3 identity readback");
    check(oe, 1'b1, "R12 oe in shift");

    // R12: tdo must not move at the rising edge
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    tms = 1'b0; tdi = 1'b0;
    @(posedge tck); #1; t_a = tdo;
    @(negedge tck); #1; t_b = tdo;
    check({t_a, t_b}, {ID_EXP[0], ID_EXP[1]}, "R12 falling-edge tdo");
    step(1'b1, 1'b0, o);
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);

    load_ir(4'b1111, cap);
    check(flags_now(), 5'b0, "R4 flags for undefined op");
    bypass_check("R4 bypass delay");
    load_ir(4'b0001, cap);
    bypass_check("R4 bypass op 0001");

    load_ir(4'b0011, cap);
    pin_in = BSR_W'($urandom);
    scan_dr(BSR_W, {32'h0, $urandom}, dout, oe);
    check(dout[BSR_W-1:0], pin_in, "R5 sample capture");
    check(pin_out, exp_pout, "R5 sample leaves pin_out");
    check(flags_now(), 5'b0, "R5 flags");

    load_ir(4'b0010, cap);
    d = BSR_W'($urandom);
    scan_dr(BSR_W, {'0, d}, dout, oe);
    exp_pout = d;
    check(pin_out, exp_pout, "R6 preload update");
    check(flags_now(), 5'b0, "R6 flags");

    c = BSR_W'($urandom); d = BSR_W'($urandom);
    pin_in = c;
    scan_dr(3, {'0, d}, dout, oe);
    exp_pout = part_shift(c, d, 3);
    check(pin_out, exp_pout, "R11 partial update");
    check(dout[2:0], c[2:0], "R11 partial read");

    load_ir(4'b0100, cap);
    check(flags_now(), 5'b10100, "R7 extest flags");
    check(pin_out, exp_pout, "R7 preload held");
    d = BSR_W'($urandom);
    scan_dr(BSR_W, {'0, d}, dout, oe);
    exp_pout = d;
    check(pin_out, exp_pout, "R7 extest update");

    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    check(flags_now(), 5'b0, "R1 five tms high");
    check(pin_out, exp_pout, "R1 tms reset keeps pin_out");
    scan_dr(32, 64'h0, dout, oe);
    check(dout[31:0], ID_EXP, "R1 identity after tms reset");

    load_ir(4'b1001, cap);
    check(flags_now(), 5'b01100, "R8 highz flags");
    bypass_check("R8 highz bypass");

    load_ir(4'b1000, cap);
    check(flags_now(), 5'b00010, "R9 debug op 1000");
    dbg_tdo = 1'b1;
    scan_dr(4, 64'h0, dout, oe);
    check(dout[3:0], 4'hF, "R9 tdo from dbg_tdo high");
    load_ir(4'b1010, cap);
    check(flags_now(), 5'b00010, "R9 debug op 1010");
    dbg_tdo = 1'b0;
    scan_dr(4, 64'hF, dout, oe);
    check(dout[3:0], 4'h0, "R9 tdo from dbg_tdo low");

    for (int k = 5; k < 8; k++) begin
      load_ir(4'(k), cap);
      check(flags_now(), 5'b00001, "R10 factory flags");
      bypass_check("R10 factory bypass");
    end

    // reset raised during a DR scan
    load_ir(4'b0100, cap);
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b1, o);
    trst = 1'b1;
    step(1'b0, 1'b1, o);
    trst = 1'b0;
    exp_pout = '0;
    check(flags_now(), 5'b0, "R1 trst mid-scan flags");
    check(pin_out, exp_pout, "R1 trst mid-scan pin_out");
    step(1'b0, 1'b0, o);
    check(tdo_oe, 1'b0, "R12 oe after reset");

    for (int n = 0; n < 40; n++) begin
      op = 4'($urandom);
      load_ir(op, cap);
      check(cap, 4'b0001, "R2 random capture");
      check(flags_now(), exp_flags(op), "R2 random decode");
      if (op == 4'b0010 || op == 4'b0100) begin
        c = BSR_W'($urandom); d = BSR_W'($urandom);
        pin_in = c;
        scan_dr(BSR_W, {'0, d}, dout, oe);
        exp_pout = d;
        check(pin_out, exp_pout, "R6 random update");
        check(dout[BSR_W-1:0], c, "R5 random capture");
      end else if (op == 4'b0011) begin
        c = BSR_W'($urandom);
        pin_in = c;
        scan_dr(BSR_W, {32'h0, $urandom}, dout, oe);
        check(dout[BSR_W-1:0], c, "R5 random sample");
        check(pin_out, exp_pout, "R5 random hold");
      end else if (op == 4'b0000) begin
        scan_dr(32, 64'h0, dout, oe);
        check(dout[31:0], ID_EXP, "R3 random identity");
      end else if (is_bypass(op)) begin
        bypass_check("R4 random bypass");
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule